// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block follows every instruction in a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and keeps a small fault vector beside it. Each stage may raise its own fault bits while the instruction passes through. The vector moves forward with the instruction in the block's own stage registers. As soon as any bit is set, the instruction loses its right to store to memory or to write a register.

Faults are acted on only when an instruction reaches write-back. This keeps traps in program order, so an older instruction always traps before a younger one, even if the younger one raised its fault first. When the write-back instruction carries a fault, the block issues a one-cycle trap pulse and encodes the highest-priority cause. It latches the faulting PC, and for an instruction that sat in a branch delay slot it also latches the branch PC and a slot marker. In the same cycle it clears the faulting instruction and every younger one. The fetch unit uses the pulse to start the handler at the next fetch.

The pipeline steps when `adv` is high and holds all tracked state when it is low. The datapath supplies, per stage, the fault conditions for the instruction in that stage and its raw write requests.

Top module: `exc_tracker`

## Requirements
- R1: Fault bits use these positions in the vector. Bit 0 is fetch page fault, bit 1 is fetch misalignment, bit 2 is fetch protection, bit 3 is undefined opcode, bit 4 is arithmetic fault, bit 5 is data page fault, bit 6 is data misalignment and bit 7 is data protection. Each bit is sampled from its stage's input while the instruction occupies that stage, and it accumulates until write-back.
- R2: The trap cause is the index of the lowest set bit plus one, so an earlier stage wins: fetch page fault is 1 and data protection is 8. The value 0 means no trap since reset.
- R3: `mem_store_en` equals `mem_store_req` only when the instruction in the memory stage is valid and carries no fault bit. This includes bits raised by the memory stage in that same cycle. Otherwise it is 0.
- R4: `wb_write_en` equals `wb_write_req` only when the write-back instruction is valid and carries no fault bit. Otherwise it is 0.
- R5: `trap_pulse` is high for exactly one cycle: the cycle after a faulting instruction occupies write-back. An instruction with no fault bit never causes a pulse.
- R6: On a trap, `trap_epc`, `trap_branch_pc` and `trap_in_slot` take the faulting instruction's PC, branch PC and delay-slot marker. All four trap outputs keep their values until the next trap.
- R7: Traps are taken in program order. An older instruction's trap is taken even when a younger one raised a fault earlier. Younger instructions then produce no trap and no write. A younger store in the memory stage during the faulting instruction's write-back cycle is suppressed.
- R8: While `adv` is low, no tracked instruction moves. A fault already recorded is taken only after the instruction reaches write-back once stepping resumes.
- R9: While `rst_n` is low at a clock edge, all tracked instructions are cleared and all trap outputs go to 0. Write enables stay 0 even when requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Pipeline steps on this edge |
| if_valid | input | 1 | A real instruction is being fetched |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_in_slot | input | 1 | Fetched instruction sits in a branch delay slot |
| if_branch_pc | input | PC_W | PC of the branch owning that slot |
| if_page_fault | input | 1 | Fetch page fault |
| if_misaligned | input | 1 | Fetch address misaligned |
| if_protect | input | 1 | Fetch protection violation |
| id_undefined | input | 1 | Decode found an undefined opcode |
| ex_arith | input | 1 | Execute raised an arithmetic fault |
| mem_page_fault | input | 1 | Data page fault |
| mem_misaligned | input | 1 | Data access misaligned |
| mem_protect | input | 1 | Data protection violation |
| mem_store_req | input | 1 | Memory-stage instruction wants to store |
| wb_write_req | input | 1 | Write-back instruction wants a register write |
| mem_store_en | output | 1 | Gated store enable |
| wb_write_en | output | 1 | Gated register write enable |
| trap_pulse | output | 1 | One-cycle trap request |
| trap_cause | output | 4 | Encoded cause of the last trap |
| trap_epc | output | PC_W | PC of the last faulting instruction |
| trap_branch_pc | output | PC_W | Branch PC when that instruction was in a slot |
| trap_in_slot | output | 1 | Last faulting instruction was in a delay slot |

## Verification
A fault bit lost or misplaced in a stage register appears at the ports within a few cycles. Either the trap pulse is missing, or it arrives with the wrong cause one cycle after the instruction reaches write-back. An enable that escapes suppression shows at once on `mem_store_en` or `wb_write_en` in the cycle the stage is occupied. A flush that misses a younger instruction shows up one to three cycles later as a second trap pulse or an unexpected write. A stage register that moves during a stall shifts the trap pulse earlier by exactly the stall length.

// File: rtl/exc_trk_pkg.sv
// Shared constants and the cause encoding for the exception tracker.
// Assumes a fixed five-stage order; fault bit index equals priority rank.
package exc_trk_pkg;
    localparam int FLAG_N   = 8;                   // fault bits per instruction
    localparam int CAUSE_W  = $clog2(FLAG_N + 1);  // room for "none" plus each bit
    localparam int STAGE_N  = 4;                   // tracked pipeline registers

    // Bit positions in the fault vector (earlier stage = lower index)
    localparam int FB_FETCH_PF   = 0;
    localparam int FB_FETCH_MIS  = 1;
    localparam int FB_FETCH_PROT = 2;
    localparam int FB_UNDEF      = 3;
    localparam int FB_ARITH      = 4;
    localparam int FB_DATA_PF    = 5;
    localparam int FB_DATA_MIS   = 6;
    localparam int FB_DATA_PROT  = 7;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE      = 4'd0,
        CAUSE_FETCH_PF  = 4'd1,
        CAUSE_FETCH_MIS = 4'd2,
        CAUSE_FETCH_PRT = 4'd3,
        CAUSE_UNDEF     = 4'd4,
        CAUSE_ARITH     = 4'd5,
        CAUSE_DATA_PF   = 4'd6,
        CAUSE_DATA_MIS  = 4'd7,
        CAUSE_DATA_PRT  = 4'd8
    } cause_e;
endpackage

// File: rtl/exc_stage_reg.sv
// One pipeline register of fault tracking state: valid, PC, delay-slot
// marker, branch PC and the accumulated fault vector.
// Assumes flush has priority over stepping; faults of bubbles are dropped.
module exc_stage_reg #(
    parameter int PC_W   = 32,
    parameter int FLAG_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              flush,
    input  logic              d_valid,
    input  logic [PC_W-1:0]   d_pc,
    input  logic              d_slot,
    input  logic [PC_W-1:0]   d_bpc,
    input  logic [FLAG_N-1:0] d_flags,
    input  logic [FLAG_N-1:0] post_flags,
    output logic              q_valid,
    output logic [PC_W-1:0]   q_pc,
    output logic              q_slot,
    output logic [PC_W-1:0]   q_bpc,
    output logic [FLAG_N-1:0] q_flags
);
    // Capture the instruction from the previous stage, merging this stage's faults
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q_valid <= 1'b0;
            q_pc    <= '0;
            q_slot  <= 1'b0;
            q_bpc   <= '0;
            q_flags <= '0;
        end else if (adv) begin
            q_valid <= d_valid;
            q_pc    <= d_pc;
            q_slot  <= d_slot;
            q_bpc   <= d_bpc;
            q_flags <= d_valid ? (d_flags | post_flags) : '0;
        end
    end
endmodule

// File: rtl/exc_cause_enc.sv
// Priority encoder: lowest set fault bit wins and is reported as index+1.
// Assumes CAUSE_W can hold FLAG_N.
module exc_cause_enc #(
    parameter int FLAG_N  = 8,
    parameter int CAUSE_W = 4
) (
    input  logic [FLAG_N-1:0]  flags,
    output logic               any,
    output logic [CAUSE_W-1:0] cause
);
    // Scan from the lowest-priority bit down so the earliest stage overrides
    always_comb begin
        cause = '0;
        for (int i = FLAG_N - 1; i >= 0; i--) begin
            if (flags[i]) cause = CAUSE_W'(i + 1);
        end
    end

    // Any bit set means the instruction must trap
    assign any = |flags;
endmodule

// File: rtl/exc_trap_capture.sv
// Trap-side registers: one-cycle pulse plus held cause and return context.
// Assumes take is asserted for one cycle per faulting instruction.
module exc_trap_capture #(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [PC_W-1:0]    bpc_in,
    input  logic               slot_in,
    output logic               pulse,
    output logic [CAUSE_W-1:0] cause,
    output logic [PC_W-1:0]    epc,
    output logic [PC_W-1:0]    bpc,
    output logic               in_slot
);
    // Pulse follows take by one edge and drops the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= take;
    end

    // Context is loaded only on a taken trap and held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause   <= '0;
            epc     <= '0;
            bpc     <= '0;
            in_slot <= 1'b0;
        end else if (take) begin
            cause   <= cause_in;
            epc     <= pc_in;
            bpc     <= slot_in ? bpc_in : '0;
            in_slot <= slot_in;
        end
    end
endmodule

// File: rtl/exc_tracker.sv
// Precise exception tracker for a five-stage in-order pipeline.
// Carries a fault vector per instruction, gates stores and register writes
// of faulted instructions, and traps in program order at write-back.
// Assumes: stage index 0 = fetch inputs, 1 = decode, 2 = execute,
// 3 = memory, 4 = write-back; all stages step together on adv.
module exc_tracker
    import exc_trk_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               if_valid,
    input  logic [PC_W-1:0]    if_pc,
    input  logic               if_in_slot,
    input  logic [PC_W-1:0]    if_branch_pc,
    input  logic               if_page_fault,
    input  logic               if_misaligned,
    input  logic               if_protect,
    input  logic               id_undefined,
    input  logic               ex_arith,
    input  logic               mem_page_fault,
    input  logic               mem_misaligned,
    input  logic               mem_protect,
    input  logic               mem_store_req,
    input  logic               wb_write_req,
    output logic               mem_store_en,
    output logic               wb_write_en,
    output logic               trap_pulse,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [PC_W-1:0]    trap_epc,
    output logic [PC_W-1:0]    trap_branch_pc,
    output logic               trap_in_slot
);
    localparam int MEM_IDX = STAGE_N - 1;
    localparam int WB_IDX  = STAGE_N;

    logic [STAGE_N:0]                  st_valid;
    logic [STAGE_N:0][PC_W-1:0]        st_pc;
    logic [STAGE_N:0]                  st_slot;
    logic [STAGE_N:0][PC_W-1:0]        st_bpc;
    logic [STAGE_N:0][FLAG_N-1:0]      st_flags;
    logic [STAGE_N-1:0][FLAG_N-1:0]    post;

    logic               wb_fault;
    logic [CAUSE_W-1:0] wb_cause;
    logic               mem_clean;

    // Stage 0 is the fetch side, taken straight from the inputs
    assign st_valid[0] = if_valid;
    assign st_pc[0]    = if_pc;
    assign st_slot[0]  = if_in_slot;
    assign st_bpc[0]   = if_branch_pc;
    assign st_flags[0] = '0;

    // Fault bits each stage posts as its instruction leaves it
    always_comb begin
        post = '0;
        post[0][FB_FETCH_PF]   = if_page_fault;
        post[0][FB_FETCH_MIS]  = if_misaligned;
        post[0][FB_FETCH_PROT] = if_protect;
        post[1][FB_UNDEF]      = id_undefined;
        post[2][FB_ARITH]      = ex_arith;
        post[3][FB_DATA_PF]    = mem_page_fault;
        post[3][FB_DATA_MIS]   = mem_misaligned;
        post[3][FB_DATA_PROT]  = mem_protect;
    end

    // Chain of tracking registers, one per pipeline boundary
    for (genvar g = 0; g < STAGE_N; g++) begin : g_stage
        exc_stage_reg #(
            .PC_W   (PC_W),
            .FLAG_N (FLAG_N)
        ) u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv        (adv),
            .flush      (wb_fault),
            .d_valid    (st_valid[g]),
            .d_pc       (st_pc[g]),
            .d_slot     (st_slot[g]),
            .d_bpc      (st_bpc[g]),
            .d_flags    (st_flags[g]),
            .post_flags (post[g]),
            .q_valid    (st_valid[g+1]),
            .q_pc       (st_pc[g+1]),
            .q_slot     (st_slot[g+1]),
            .q_bpc      (st_bpc[g+1]),
            .q_flags    (st_flags[g+1])
        );
    end

    // Examine the write-back instruction's vector
    exc_cause_enc #(
        .FLAG_N  (FLAG_N),
        .CAUSE_W (CAUSE_W)
    ) u_enc (
        .flags (st_flags[WB_IDX]),
        .any   (),
        .cause (wb_cause)
    );

    // A valid write-back instruction with any fault takes the trap
    assign wb_fault = st_valid[WB_IDX] && (wb_cause != '0);

    // Memory-stage store allowed only for a clean, unflushed instruction
    assign mem_clean    = st_valid[MEM_IDX] && ((st_flags[MEM_IDX] | post[MEM_IDX]) == '0);
    assign mem_store_en = mem_store_req && mem_clean && !wb_fault;

    // Register write allowed only for a clean write-back instruction
    assign wb_write_en  = wb_write_req && st_valid[WB_IDX] && (st_flags[WB_IDX] == '0);

    // Trap pulse and saved return context
    exc_trap_capture #(
        .PC_W    (PC_W),
        .CAUSE_W (CAUSE_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (wb_fault),
        .cause_in (wb_cause),
        .pc_in    (st_pc[WB_IDX]),
        .bpc_in   (st_bpc[WB_IDX]),
        .slot_in  (st_slot[WB_IDX]),
        .pulse    (trap_pulse),
        .cause    (trap_cause),
        .epc      (trap_epc),
        .bpc      (trap_branch_pc),
        .in_slot  (trap_in_slot)
    );
endmodule

// File: rtl/exc_tracker_chk.sv
// Port-level properties of the exception tracker, bound into every instance.
module exc_tracker_chk #(
    parameter int PC_W    = 32,
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_store_req,
    input logic               mem_store_en,
    input logic               wb_write_req,
    input logic               wb_write_en,
    input logic               trap_pulse,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [PC_W-1:0]    trap_epc
);
    // R3
    store_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_store_en |-> mem_store_req);

    // R4
    write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_write_en |-> wb_write_req);

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !trap_pulse);

    // R5
    clean_wb_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_write_en |=> !trap_pulse);

    // R2
    cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (trap_cause != '0 && trap_cause <= CAUSE_W'(8)));

    // R6
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trap_epc) |-> trap_pulse);

    // R7
    flushed_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> !wb_write_en);
endmodule

bind exc_tracker exc_tracker_chk #(
    .PC_W    (PC_W),
    .CAUSE_W (exc_trk_pkg::CAUSE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_store_req (mem_store_req),
    .mem_store_en  (mem_store_en),
    .wb_write_req  (wb_write_req),
    .wb_write_en   (wb_write_en),
    .trap_pulse    (trap_pulse),
    .trap_cause    (trap_cause),
    .trap_epc      (trap_epc)
);

// File: tb/exc_tracker_bench.sv
`timescale 1ns/1ps
module exc_tracker_bench;
    localparam int PC_W = 32;

    typedef struct packed {
        logic            v;
        logic [PC_W-1:0] pc;
        logic            slot;
        logic [PC_W-1:0] bpc;
        logic [7:0]      fl;
        logic            st;
        logic            wr;
    } instr_t;

    localparam instr_t NOP = '0;
    localparam int NROW = 9;
    // Single-instruction vectors: fault bits as in R1, expected cause per R2
    localparam instr_t TBL [NROW] = '{
        '{1'b1, 32'h0000_0100, 1'b0, 32'h0, 8'h00, 1'b1, 1'b1},
        '{1'b1, 32'h0000_0104, 1'b0, 32'h0, 8'h01, 1'b1, 1'b1},
        '{1'b1, 32'h0000_0108, 1'b0, 32'h0, 8'h06, 1'b0, 1'b1},
        '{1'b1, 32'h0000_010C, 1'b0, 32'h0, 8'h08, 1'b1, 1'b1},
        '{1'b1, 32'h0000_0110, 1'b0, 32'h0, 8'h10, 1'b1, 1'b1},
        '{1'b1, 32'h0000_0114, 1'b0, 32'h0, 8'hE0, 1'b1, 1'b0},
        '{1'b1, 32'h0000_0118, 1'b0, 32'h0, 8'h90, 1'b1, 1'b1},
        '{1'b1, 32'h0000_0300, 1'b1, 32'h0000_02FC, 8'h80, 1'b1, 1'b1},
        '{1'b1, 32'h0000_0304, 1'b1, 32'h0000_0300, 8'h40, 1'b0, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            adv;
    logic            if_valid, if_in_slot;
    logic [PC_W-1:0] if_pc, if_branch_pc;
    logic            if_page_fault, if_misaligned, if_protect;
    logic            id_undefined, ex_arith;
    logic            mem_page_fault, mem_misaligned, mem_protect;
    logic            mem_store_req, wb_write_req;
    logic            mem_store_en, wb_write_en, trap_pulse, trap_in_slot;
    logic [3:0]      trap_cause;
    logic [PC_W-1:0] trap_epc, trap_branch_pc;

    int total = 0;
    int bad   = 0;
    instr_t sh [5];
    logic [PC_W-1:0] last_epc;

    always #2.5 clk = ~clk;

    exc_tracker #(.PC_W(PC_W)) u_exc_tracker (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .if_valid(if_valid), .if_pc(if_pc), .if_in_slot(if_in_slot),
        .if_branch_pc(if_branch_pc), .if_page_fault(if_page_fault),
        .if_misaligned(if_misaligned), .if_protect(if_protect),
        .id_undefined(id_undefined), .ex_arith(ex_arith),
        .mem_page_fault(mem_page_fault), .mem_misaligned(mem_misaligned),
        .mem_protect(mem_protect), .mem_store_req(mem_store_req),
        .wb_write_req(wb_write_req), .mem_store_en(mem_store_en),
        .wb_write_en(wb_write_en), .trap_pulse(trap_pulse),
        .trap_cause(trap_cause), .trap_epc(trap_epc),
        .trap_branch_pc(trap_branch_pc), .trap_in_slot(trap_in_slot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cause(input logic [7:0] fl);
        for (int i = 0; i < 8; i++) if (fl[i]) return 4'(i + 1);
        return 4'd0;
    endfunction

    // Present each shadow stage's stimulus on the ports
    task automatic drive();
        if_valid       = sh[0].v;
        if_pc          = sh[0].pc;
        if_in_slot     = sh[0].slot;
        if_branch_pc   = sh[0].bpc;
        if_page_fault  = sh[0].fl[0];
        if_misaligned  = sh[0].fl[1];
        if_protect     = sh[0].fl[2];
        id_undefined   = sh[1].fl[3];
        ex_arith       = sh[2].fl[4];
        mem_page_fault = sh[3].fl[5];
        mem_misaligned = sh[3].fl[6];
        mem_protect    = sh[3].fl[7];
        mem_store_req  = sh[3].st;
        wb_write_req   = sh[4].wr;
    endtask

    // Offer x at fetch, step one clock, redrive, settle for sampling
    task automatic cyc(input instr_t x, input logic step);
        sh[0] = x;
        adv = step;
        drive();
        @(posedge clk);
        if (step) begin
            for (int k = 4; k > 0; k--) sh[k] = sh[k-1];
            sh[0] = NOP;
        end
        @(negedge clk);
        adv = 1'b1;
        drive();
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) sh[k] = NOP;
        rst_n = 1'b0;
        adv = 1'b1;
        drive();
        mem_store_req = 1'b1;
        wb_write_req  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R9: reset state with write requests forced high
        check("R9 pulse", trap_pulse, 0);
        check("R9 cause", trap_cause, 0);
        check("R9 epc", trap_epc, 0);
        check("R9 store_en", mem_store_en, 0);
        check("R9 write_en", wb_write_en, 0);
        rst_n = 1'b1;
        drive();
        last_epc = '0;

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int r = 0; r < NROW; r++) begin
            automatic instr_t t = TBL[r];
            automatic logic   f = (t.fl != 8'h00);
            cyc(t, 1'b1);
            cyc(NOP, 1'b1);
            cyc(NOP, 1'b1);
            check("R3 store gate", mem_store_en, t.st & !f);
            cyc(NOP, 1'b1);
            check("R4 write gate", wb_write_en, t.wr & !f);
            check("R5 no early pulse", trap_pulse, 0);
            cyc(NOP, 1'b1);
            check("R5 pulse", trap_pulse, f);
            if (f) begin
                check("R2 R1 cause", trap_cause, exp_cause(t.fl));
                check("R6 epc", trap_epc, t.pc);
                check("R6 slot", trap_in_slot, t.slot);
                check("R6 branch pc", trap_branch_pc, t.slot ? t.bpc : 0);
                last_epc = t.pc;
            end else begin
                check("R6 epc held", trap_epc, last_epc);
            end
            cyc(NOP, 1'b1);
            check("R5 pulse one cycle", trap_pulse, 0);
        end

        // R7: older data fault wins over younger earlier fetch fault
        begin
            automatic instr_t a = '{1'b1, 32'h200, 1'b0, 32'h0, 8'h20, 1'b0, 1'b1};
            automatic instr_t b = '{1'b1, 32'h204, 1'b0, 32'h0, 8'h00, 1'b1, 1'b1};
            automatic instr_t c = '{1'b1, 32'h208, 1'b0, 32'h0, 8'h01, 1'b1, 1'b1};
            cyc(a, 1'b1);
            cyc(b, 1'b1);
            cyc(c, 1'b1);
            cyc(NOP, 1'b1);
            check("R7 younger store suppressed", mem_store_en, 0);
            check("R4 faulted write suppressed", wb_write_en, 0);
            cyc(NOP, 1'b1);
            check("R7 older trap taken", trap_pulse, 1);
            check("R7 cause of older", trap_cause, 6);
            check("R7 epc of older", trap_epc, 32'h200);
            for (int i = 0; i < 5; i++) begin
                cyc(NOP, 1'b1);
                check("R7 younger no trap", trap_pulse, 0);
                check("R7 younger no write", wb_write_en, 0);
            end
            check("R6 epc held after flush", trap_epc, 32'h200);
        end

        // R8: stall holds a faulting instruction in execute
        begin
            automatic instr_t s = '{1'b1, 32'h400, 1'b0, 32'h0, 8'h10, 1'b0, 1'b1};
            cyc(s, 1'b1);
            cyc(NOP, 1'b1);
            for (int i = 0; i < 3; i++) begin
                cyc(NOP, 1'b0);
                check("R8 stalled no trap", trap_pulse, 0);
            end
            cyc(NOP, 1'b1);
            cyc(NOP, 1'b1);
            check("R8 not yet", trap_pulse, 0);
            cyc(NOP, 1'b1);
            check("R8 trap after resume", trap_pulse, 1);
            check("R8 cause", trap_cause, 5);
            check("R8 epc", trap_epc, 32'h400);
        end

        // R3: memory-stage fault raised in the same cycle blocks the store
        begin
            automatic instr_t m = '{1'b1, 32'h500, 1'b0, 32'h0, 8'h80, 1'b1, 1'b0};
            cyc(m, 1'b1);
            cyc(NOP, 1'b1);
            cyc(NOP, 1'b1);
            check("R3 same-cycle mem fault", mem_store_en, 0);
            cyc(NOP, 1'b1);
            cyc(NOP, 1'b1);
            check("R2 data protect cause", trap_cause, 8);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule